// File: doc/BRIEF.md
# Multiplexed Bus Address Demultiplexer and Memory Strobe Glue

This block joins a microcontroller that multiplexes its low address byte and its data onto one port with an external code ROM and an external data RAM. While the address-latch-enable input is high, the low address byte passes straight through from the multiplexed port. When that input drops, the byte is frozen and held until the next latch-enable pulse, whatever the multiplexed port carries afterwards (typically data). The full memory address is the high-address port on top and the held low byte below it, and both memories see the same address.

The processor's active-low strobes are mapped onto the memory pins. The program-fetch strobe enables the ROM output, the data-read strobe enables the RAM output and the data-write strobe drives the RAM write enable. The ROM has no write path. A combined read strobe, low when either read strobe is low, is always produced. A mode parameter selects split operation (separate ROM and RAM) or unified operation, where one shared memory takes its output enable from the combined strobe and the ROM enable stays inactive. Active-low chip selects for the RAM and the ROM are decoded from parameterised base and size windows.

The block runs on a system clock that oversamples the bus. The held byte is the value seen at the last clock edge on which latch enable was high.

Top module: `addr_demux_glue`

## Requirements
- R1: While `ale` is 1, `mem_addr[7:0]` equals `port_mux` in the same cycle, with no clock delay.
- R2: While `ale` is 0, `mem_addr[7:0]` holds the `port_mux` value sampled at the last rising clock edge with `ale` 1, and later changes on `port_mux` have no effect on it.
- R3: `mem_addr[15:8]` always equals `port_hi`.
- R4: In split mode (`MODE` = `MODE_SPLIT`), `rom_oe_n` equals `psen_n`.
- R5: In split mode `ram_oe_n` equals `rd_n`, and in both modes `ram_we_n` equals `wr_n`.
- R6: `comb_rd_n` is 0 exactly when `rd_n` is 0 or `psen_n` is 0.
- R7: In unified mode (`MODE` = `MODE_UNIFIED`), `ram_oe_n` equals `comb_rd_n` and `rom_oe_n` stays 1.
- R8: `ram_cs_n` is 0 exactly when `RAM_BASE <= mem_addr < RAM_BASE + RAM_SIZE` (defaults 16'h4000 and 16'h1000).
- R9: `rom_cs_n` is 0 exactly when `ROM_BASE <= mem_addr < ROM_BASE + ROM_SIZE` (defaults 16'h0000 and 16'h2000).
- R10: After reset, with `ale` held 0 from reset onward, the held low byte is 8'h00.
- R11: With legal strobes (never `rd_n` and `wr_n` low together, never `psen_n` and `wr_n` low together), `ram_we_n` and `comb_rd_n` are never both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_hi | input | 8 | High address byte from the processor |
| port_mux | input | 8 | Multiplexed low address / data port |
| ale | input | 1 | Address latch enable, high while the port carries the address |
| psen_n | input | 1 | Program fetch strobe, active low |
| rd_n | input | 1 | Data read strobe, active low |
| wr_n | input | 1 | Data write strobe, active low |
| mem_addr | output | 16 | Demultiplexed memory address |
| rom_oe_n | output | 1 | ROM output enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| comb_rd_n | output | 1 | Combined code/data read strobe, active low |
| rom_cs_n | output | 1 | ROM window chip select, active low |
| ram_cs_n | output | 1 | RAM window chip select, active low |

## Verification
The assertions check on every cycle the pass-through of the low byte while latch enable is high, the hold after its falling edge, the high-byte mapping, the per-mode strobe mapping, the RAM window and the legality of the incoming strobes. Only the bench's scenarios show the reset value of the held byte, the edges of both windows reached from either side, and the unified mode set against split mode on the same stimulus. The bench also shows that traffic on the multiplexed port during a long hold never reaches the address.

// File: rtl/addr_glue_pkg.sv
package addr_glue_pkg;

  typedef enum logic {
    MODE_SPLIT   = 1'b0,
    MODE_UNIFIED = 1'b1
  } bus_mode_e;

  typedef struct packed {
    logic rom_oe_n;
    logic ram_oe_n;
    logic ram_we_n;
    logic comb_rd_n;
  } strobe_t;

  // half-open window test on a zero-extended address
  function automatic logic win_hit(input logic [31:0] addr,
                                   input logic [31:0] base,
                                   input logic [31:0] size);
    logic [32:0] top;
    top = {1'b0, base} + {1'b0, size};
    return ({1'b0, addr} >= {1'b0, base}) && ({1'b0, addr} < top);
  endfunction

  // active-low OR of two active-low read strobes
  function automatic logic any_read_n(input logic a_n, input logic b_n);
    return ~((~a_n) | (~b_n));
  endfunction

endpackage

// File: rtl/glue_lo_latch.sv
module glue_lo_latch #(
  parameter int LO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ale,
  input  logic [LO_W-1:0] port_mux,
  output logic [LO_W-1:0] lo_byte,
  output logic            ale_fell
);

  logic [LO_W-1:0] hold_q;
  logic            ale_q;

  // one sampling cell per address bit
  for (genvar b = 0; b < LO_W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_q[b] <= 1'b0;
      end else if (ale) begin
        hold_q[b] <= port_mux[b];
      end
    end
    // transparent while enable is high, frozen otherwise
    assign lo_byte[b] = ale ? port_mux[b] : hold_q[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_q <= 1'b0;
    end else begin
      ale_q <= ale;
    end
  end

  assign ale_fell = ale_q & ~ale;

endmodule

// File: rtl/glue_strobe_map.sv
module glue_strobe_map
  import addr_glue_pkg::*;
#(
  parameter bus_mode_e MODE = MODE_SPLIT
) (
  input  logic    psen_n,
  input  logic    rd_n,
  input  logic    wr_n,
  output strobe_t strobes,
  output logic    rd_wr_clash,
  output logic    fetch_wr_clash
);

  logic comb_n;

  assign comb_n = any_read_n(rd_n, psen_n);

  if (MODE == MODE_SPLIT) begin : g_split
    assign strobes.rom_oe_n = psen_n;
    assign strobes.ram_oe_n = rd_n;
  end else begin : g_unified
    assign strobes.rom_oe_n = 1'b1;
    assign strobes.ram_oe_n = comb_n;
  end

  assign strobes.ram_we_n  = wr_n;
  assign strobes.comb_rd_n = comb_n;

  // illegal strobe overlaps, brought out for the checker
  assign rd_wr_clash    = ~rd_n & ~wr_n;
  assign fetch_wr_clash = ~psen_n & ~wr_n;

endmodule

// File: rtl/glue_window_dec.sv
module glue_window_dec
  import addr_glue_pkg::*;
#(
  parameter int          AW   = 16,
  parameter int unsigned BASE = 0,
  parameter int unsigned SIZE = 1
) (
  input  logic [AW-1:0] addr,
  output logic          cs_n
);

  logic [31:0] addr_ext;

  if (AW < 32) begin : g_ext
    assign addr_ext = {{(32-AW){1'b0}}, addr};
  end else begin : g_full
    assign addr_ext = addr[31:0];
  end

  assign cs_n = ~win_hit(addr_ext, BASE, SIZE);

endmodule

// File: rtl/addr_demux_glue.sv
module addr_demux_glue
  import addr_glue_pkg::*;
#(
  parameter int          HI_W     = 8,
  parameter int          LO_W     = 8,
  parameter bus_mode_e   MODE     = MODE_SPLIT,
  parameter int unsigned RAM_BASE = 32'h4000,
  parameter int unsigned RAM_SIZE = 32'h1000,
  parameter int unsigned ROM_BASE = 32'h0000,
  parameter int unsigned ROM_SIZE = 32'h2000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [HI_W-1:0]      port_hi,
  input  logic [LO_W-1:0]      port_mux,
  input  logic                 ale,
  input  logic                 psen_n,
  input  logic                 rd_n,
  input  logic                 wr_n,
  output logic [HI_W+LO_W-1:0] mem_addr,
  output logic                 rom_oe_n,
  output logic                 ram_oe_n,
  output logic                 ram_we_n,
  output logic                 comb_rd_n,
  output logic                 rom_cs_n,
  output logic                 ram_cs_n
);

  localparam int AW = HI_W + LO_W;

  logic [LO_W-1:0] lo_byte;
  logic            ale_fell;
  strobe_t         strobes;
  logic            rd_wr_clash;
  logic            fetch_wr_clash;

  glue_lo_latch #(.LO_W(LO_W)) u_lo_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .ale      (ale),
    .port_mux (port_mux),
    .lo_byte  (lo_byte),
    .ale_fell (ale_fell)
  );

  assign mem_addr = {port_hi, lo_byte};

  glue_strobe_map #(.MODE(MODE)) u_strobe_map (
    .psen_n         (psen_n),
    .rd_n           (rd_n),
    .wr_n           (wr_n),
    .strobes        (strobes),
    .rd_wr_clash    (rd_wr_clash),
    .fetch_wr_clash (fetch_wr_clash)
  );

  assign rom_oe_n  = strobes.rom_oe_n;
  assign ram_oe_n  = strobes.ram_oe_n;
  assign ram_we_n  = strobes.ram_we_n;
  assign comb_rd_n = strobes.comb_rd_n;

  glue_window_dec #(.AW(AW), .BASE(RAM_BASE), .SIZE(RAM_SIZE)) u_ram_win (
    .addr (mem_addr),
    .cs_n (ram_cs_n)
  );

  glue_window_dec #(.AW(AW), .BASE(ROM_BASE), .SIZE(ROM_SIZE)) u_rom_win (
    .addr (mem_addr),
    .cs_n (rom_cs_n)
  );

endmodule

// File: rtl/addr_demux_glue_chk.sv
module addr_demux_glue_chk
  import addr_glue_pkg::*;
#(
  parameter int          HI_W     = 8,
  parameter int          LO_W     = 8,
  parameter bus_mode_e   MODE     = MODE_SPLIT,
  parameter int unsigned RAM_BASE = 32'h4000,
  parameter int unsigned RAM_SIZE = 32'h1000
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ale,
  input logic [LO_W-1:0]      port_mux,
  input logic [HI_W-1:0]      port_hi,
  input logic [HI_W+LO_W-1:0] mem_addr,
  input logic                 psen_n,
  input logic                 rd_n,
  input logic                 wr_n,
  input logic                 rom_oe_n,
  input logic                 ram_oe_n,
  input logic                 ram_we_n,
  input logic                 comb_rd_n,
  input logic                 ram_cs_n,
  input logic                 ale_fell,
  input logic                 rd_wr_clash,
  input logic                 fetch_wr_clash
);

  localparam int AW = HI_W + LO_W;

  logic [LO_W-1:0] lo_view;
  logic [32:0]     addr_wide;
  assign lo_view   = mem_addr[LO_W-1:0];
  assign addr_wide = {{(33-AW){1'b0}}, mem_addr};

  assert_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (lo_view == port_mux));

  assert_hold_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ale_fell && $past(rst_n)) |-> (lo_view == $past(port_mux)));

  assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && !$past(ale) && $past(rst_n)) |-> $stable(lo_view));

  assert_high_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_addr[AW-1:LO_W] == port_hi);

  if (MODE == MODE_SPLIT) begin : g_split_chk
    assert_rom_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rom_oe_n == psen_n);
    assert_ram_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ram_oe_n == rd_n);
  end else begin : g_uni_chk
    assert_unified_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rom_oe_n && (ram_oe_n == comb_rd_n));
  end

  assert_ram_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_n == wr_n);

  assert_comb_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!comb_rd_n) == (!rd_n || !psen_n));

  assert_ram_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_cs_n) == ((addr_wide >= {1'b0, RAM_BASE}) &&
                    (addr_wide - {1'b0, RAM_BASE} < {1'b0, RAM_SIZE})));

  assert_strobe_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_wr_clash && !fetch_wr_clash);

  assert_no_read_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_n || comb_rd_n);

endmodule

bind addr_demux_glue addr_demux_glue_chk #(
  .HI_W(HI_W), .LO_W(LO_W), .MODE(MODE),
  .RAM_BASE(RAM_BASE), .RAM_SIZE(RAM_SIZE)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ale            (ale),
  .port_mux       (port_mux),
  .port_hi        (port_hi),
  .mem_addr       (mem_addr),
  .psen_n         (psen_n),
  .rd_n           (rd_n),
  .wr_n           (wr_n),
  .rom_oe_n       (rom_oe_n),
  .ram_oe_n       (ram_oe_n),
  .ram_we_n       (ram_we_n),
  .comb_rd_n      (comb_rd_n),
  .ram_cs_n       (ram_cs_n),
  .ale_fell       (ale_fell),
  .rd_wr_clash    (rd_wr_clash),
  .fetch_wr_clash (fetch_wr_clash)
);

// File: tb/test_addr_demux_glue.sv
`timescale 1ns/1ps
module test_addr_demux_glue;
  import addr_glue_pkg::*;

  localparam int RAM_B = 'h4000;
  localparam int RAM_S = 'h1000;
  localparam int ROM_B = 'h0000;
  localparam int ROM_S = 'h2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] port_hi = '0, port_mux = '0;
  logic ale = 1'b0, psen_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;

  logic [15:0] s_addr, u_addr;
  logic s_rom_oe, s_ram_oe, s_we, s_comb, s_rom_cs, s_ram_cs;
  logic u_rom_oe, u_ram_oe, u_we, u_comb, u_rom_cs, u_ram_cs;

  always #5 clk = ~clk;

  addr_demux_glue i_addr_demux_glue (
    .clk(clk), .rst_n(rst_n), .port_hi(port_hi), .port_mux(port_mux),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .mem_addr(s_addr), .rom_oe_n(s_rom_oe), .ram_oe_n(s_ram_oe),
    .ram_we_n(s_we), .comb_rd_n(s_comb), .rom_cs_n(s_rom_cs), .ram_cs_n(s_ram_cs)
  );

  addr_demux_glue #(.MODE(MODE_UNIFIED)) i_addr_demux_glue_uni (
    .clk(clk), .rst_n(rst_n), .port_hi(port_hi), .port_mux(port_mux),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .mem_addr(u_addr), .rom_oe_n(u_rom_oe), .ram_oe_n(u_ram_oe),
    .ram_we_n(u_we), .comb_rd_n(u_comb), .rom_cs_n(u_rom_cs), .ram_cs_n(u_ram_cs)
  );

  typedef struct {
    string       lo_tag;
    logic [15:0] addr;
    logic rom_oe, ram_oe, we, comb, rom_cs, ram_cs, uni_ram_oe;
  } exp_t;

  exp_t sb_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] hold_m = '0;
  logic       prev_ale = 1'b0;
  logic [7:0] prev_mux = '0;

  task automatic cmp(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic in_win(input logic [15:0] a, input int b, input int s);
    return (int'(a) >= b) && (int'(a) < b + s);
  endfunction

  // driver: apply one bus state at a falling edge and queue what must appear
  task automatic drive(input logic [7:0] hi, input logic [7:0] mx, input logic a,
                       input logic ps, input logic rd, input logic wr, input string tag);
    exp_t e;
    @(negedge clk);
    if (prev_ale) hold_m = prev_mux;   // capture at the rising edge just passed
    port_hi = hi; port_mux = mx; ale = a; psen_n = ps; rd_n = rd; wr_n = wr;
    e.lo_tag     = tag;
    e.addr       = {hi, a ? mx : hold_m};
    e.rom_oe     = ps;
    e.ram_oe     = rd;
    e.we         = wr;
    e.comb       = !((rd == 1'b0) || (ps == 1'b0));
    e.uni_ram_oe = e.comb;
    e.ram_cs     = !in_win(e.addr, RAM_B, RAM_S);
    e.rom_cs     = !in_win(e.addr, ROM_B, ROM_S);
    sb_q.push_back(e);
    prev_ale = a;
    prev_mux = mx;
  endtask

  // monitor: compare well after the falling edge, away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        cmp({e.lo_tag, " low byte"}, {8'h00, s_addr[7:0]}, {8'h00, e.addr[7:0]});
        cmp("R3 high byte", {8'h00, s_addr[15:8]}, {8'h00, e.addr[15:8]});
        cmp("R4 rom_oe_n", {15'h0, s_rom_oe}, {15'h0, e.rom_oe});
        cmp("R5 ram_oe_n", {15'h0, s_ram_oe}, {15'h0, e.ram_oe});
        cmp("R5 ram_we_n", {15'h0, s_we}, {15'h0, e.we});
        cmp("R5 unified ram_we_n", {15'h0, u_we}, {15'h0, e.we});
        cmp("R6 comb_rd_n", {15'h0, s_comb}, {15'h0, e.comb});
        cmp("R7 unified ram_oe_n", {15'h0, u_ram_oe}, {15'h0, e.uni_ram_oe});
        cmp("R7 unified rom_oe_n", {15'h0, u_rom_oe}, 16'h0001);
        cmp("R7 unified address", u_addr, e.addr);
        cmp("R8 ram_cs_n", {15'h0, s_ram_cs}, {15'h0, e.ram_cs});
        cmp("R9 rom_cs_n", {15'h0, s_rom_cs}, {15'h0, e.rom_cs});
        cmp("R11 write with read", {15'h0, s_we | s_comb}, 16'h0001);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // reset with latch enable low
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    hold_m = '0;
    drive(8'h12, 8'hA5, 1'b0, 1'b1, 1'b1, 1'b1, "R10 reset hold");
    drive(8'h12, 8'h5A, 1'b0, 1'b1, 1'b1, 1'b1, "R10 reset hold");

    // pass-through while enable is high
    drive(8'h30, 8'h3C, 1'b1, 1'b1, 1'b1, 1'b1, "R1 follow");
    drive(8'h30, 8'h7E, 1'b1, 1'b1, 1'b1, 1'b1, "R1 follow");
    // falling edge, then port traffic during the hold
    drive(8'h30, 8'h99, 1'b0, 1'b1, 1'b0, 1'b1, "R2 hold");
    drive(8'h30, 8'h11, 1'b0, 1'b1, 1'b1, 1'b1, "R2 hold");
    for (int k = 0; k < 6; k++)
      drive(8'h30, 8'(k * 37), 1'b0, 1'b1, 1'b1, (k % 2 == 0) ? 1'b0 : 1'b1, "R2 hold");

    // window edges for RAM and ROM
    drive(8'h3F, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b1, "R1 follow");
    drive(8'h40, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, "R1 follow");
    drive(8'h4F, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b1, "R1 follow");
    drive(8'h50, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, "R1 follow");
    drive(8'h1F, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b1, "R1 follow");
    drive(8'h20, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, "R1 follow");
    drive(8'h00, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, "R1 follow");

    // full bus cycles: fetch, read, write, idle over a spread of pages
    for (int p = 0; p < 16; p++) begin
      logic [7:0] hi;
      hi = 8'(p * 17);
      drive(hi, 8'(p * 29 + 3), 1'b1, 1'b1, 1'b1, 1'b1, "R1 follow");
      drive(hi, 8'hC3, 1'b0, 1'b0, 1'b1, 1'b1, "R2 hold");
      drive(hi, 8'(p + 90), 1'b1, 1'b1, 1'b1, 1'b1, "R1 follow");
      drive(hi, 8'h5A, 1'b0, 1'b1, 1'b0, 1'b1, "R2 hold");
      drive(hi, 8'(p * 7), 1'b1, 1'b1, 1'b1, 1'b1, "R1 follow");
      drive(hi, 8'hE1, 1'b0, 1'b1, 1'b1, 1'b0, "R2 hold");
      drive(hi, 8'h0F, 1'b0, 1'b1, 1'b1, 1'b1, "R2 hold");
    end

    // fetch and data read at once
    drive(8'h44, 8'h21, 1'b1, 1'b0, 1'b0, 1'b1, "R1 follow");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule